// File: doc/BRIEF.md
# ATA PIO Access Sequencer

This block carries out one register or PIO data access on a parallel ATA-style device bus. The host hands over a request through a valid/ready pair. The request holds a direction flag, a 3-bit register address, two chip-select bits and a 16-bit write word. The block then steps the device bus through four timed phases:

- address setup,
- a strobe phase that the device may stretch,
- recovery, which also serves as address hold,
- write-data hold, which runs inside recovery.

Every phase length comes from its own clock-count input. The result is a one-clock done pulse, together with the captured 16-bit read word for reads.

Back-pressure works as follows. `req_ready` is high only while the block is idle. A request moves only in a cycle where `req_valid` and `req_ready` are both high. A request presented while the block is busy waits, unchanged in effect, until `req_ready` returns. The result side has no back-pressure: `done` is a single-cycle pulse. `rd_data` then holds its value until the next read completes.

The device-ready input is asynchronous and is synchronized before use. The bidirectional data bus is presented as a separate output word, input word and output enable, so that the pad ring can build the tri-state driver.

Top module: `pio_access_seq`

## Requirements
- R1: After reset both strobes are high, `bus_cs_n` is 2'b11, `bus_dq_oe` is 0, `done` is 0 and `req_ready` is 1.
- R2: From the cycle after acceptance, `bus_addr` equals the request address and `bus_cs_n` equals the bitwise inverse of the request chip-select bits. This lasts for exactly max(T1,1) cycles before a strobe goes low.
- R3: With the ready line high, the strobe stays low for exactly max(T2,1) cycles.
- R4: After the strobe rises, address and chip selects stay valid for exactly max(TEOC,1) recovery cycles. `done` is high in the next cycle, and in that cycle `bus_cs_n` is 2'b11.
- R5: On a write, `bus_dq_oe` is 1 and `bus_dq_o` equals the write word from the first setup cycle through the strobe. `bus_dq_oe` then stays high for min(max(T4,1), max(TEOC,1)) recovery cycles.
- R6: On a read, `rd_data` equals the `bus_dq_i` value present during the last strobe-low cycle, and `bus_dq_oe` stays 0 throughout the access.
- R7: If `bus_rdy` is low from before the access and rises during strobe cycle k, the strobe lasts max(T2,1, k+2) cycles. The extra two cycles are the synchronizer delay.
- R8: The timing counts are latched at acceptance. Changing the count inputs during an access does not alter that access.
- R9: A timing count of 0 behaves exactly as a count of 1.
- R10: `req_ready` is 0 from the cycle after acceptance until the done cycle, in which it is 1. A request held valid during the access is accepted at the end of the done cycle.
- R11: A read drives only `bus_rd_n` low and a write drives only `bus_wr_n` low; the two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 3 | Device register address |
| req_cs | input | 2 | Chip-select bits, 1 = select asserted |
| req_wdata | input | 16 | Write word |
| cfg_t_setup | input | 8 | Address setup clocks (T1) |
| cfg_t_strobe | input | 8 | Minimum strobe width clocks (T2) |
| cfg_t_recov | input | 8 | Recovery / address hold clocks (TEOC) |
| cfg_t_whold | input | 8 | Write-data hold clocks (T4) |
| done | output | 1 | One-clock access-complete pulse |
| rd_data | output | 16 | Word captured by the last read |
| bus_addr | output | 3 | Device address lines |
| bus_cs_n | output | 2 | Active-low chip selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_dq_o | output | 16 | Data bus drive value |
| bus_dq_oe | output | 1 | Data bus output enable |
| bus_dq_i | input | 16 | Data bus sampled value |
| bus_rdy | input | 1 | Device ready, asynchronous |

## Verification
Two events can fall in the same cycle: the done pulse of one access and the acceptance of the next request. The bench provokes this by keeping a second request valid for the whole of a first access. It then judges two things: `req_ready` stays low until the done cycle, and in the cycle after done the new chip selects appear with `req_ready` low again. Ready stretching is also combined with a minimum strobe width, so that both the release taken on the width count and the release taken on the synchronized ready are exercised.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_RECOV  = 2'd3
  } pio_phase_e;
endpackage

// File: rtl/pio_rdy_sync.sv
module pio_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= 1'b0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/pio_phase_ctrl.sv
module pio_phase_ctrl
  import pio_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] t_setup,
  input  logic [CNT_W-1:0] t_strobe,
  input  logic [CNT_W-1:0] t_recov,
  input  logic             rdy_s,
  output pio_phase_e       phase,
  output logic             release_now,
  output logic             recov_last,
  output logic             done
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] strobe_q;
  logic [CNT_W-1:0] recov_q;

  assign release_now = (phase == PH_STROBE) && (cnt == ONE) && rdy_s;
  assign recov_last  = (phase == PH_RECOV) && (cnt == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= ONE;
      strobe_q <= ONE;
      recov_q  <= ONE;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) begin
          phase    <= PH_SETUP;
          cnt      <= at_least_one(t_setup);
          strobe_q <= at_least_one(t_strobe);
          recov_q  <= at_least_one(t_recov);
        end
        PH_SETUP: if (cnt == ONE) begin
          phase <= PH_STROBE;
          cnt   <= strobe_q;
        end else begin
          cnt <= cnt - ONE;
        end
        PH_STROBE: if (release_now) begin
          phase <= PH_RECOV;
          cnt   <= recov_q;
        end else if (cnt != ONE) begin
          cnt <= cnt - ONE;
        end
        PH_RECOV: if (recov_last) begin
          phase <= PH_IDLE;
          done  <= 1'b1;
        end else begin
          cnt <= cnt - ONE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // independent strobe-length tally for the width check
  logic [CNT_W:0] strobe_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  strobe_len <= '0;
    else if (phase != PH_STROBE) strobe_len <= '0;
    else                         strobe_len <= strobe_len + 1'b1;
  end

  AST_MIN_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    release_now |-> ({1'b0, strobe_q} <= strobe_len + 1'b1)); // R3
  AST_RDY_LOW_HOLDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STROBE && !rdy_s) |=> (phase == PH_STROBE)); // R7
  AST_COUNT_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> (cnt != '0)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
endmodule

// File: rtl/pio_bus_drv.sv
module pio_bus_drv
  import pio_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  parameter int CS_W   = 2,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CS_W-1:0]   req_cs,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CNT_W-1:0]  t_whold,
  input  pio_phase_e        phase,
  input  logic              release_now,
  input  logic              recov_last,
  input  logic [DATA_W-1:0] bus_dq_i,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [CS_W-1:0]   bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [DATA_W-1:0] bus_dq_o,
  output logic              bus_dq_oe,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic              wr_q;
  logic              active;
  logic [CS_W-1:0]   cs_q;
  logic [CNT_W-1:0]  hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q      <= 1'b0;
      active    <= 1'b0;
      cs_q      <= '0;
      bus_addr  <= '0;
      bus_dq_o  <= '0;
      bus_dq_oe <= 1'b0;
      hold_cnt  <= ONE;
      rd_data   <= '0;
    end else begin
      if (start) begin
        wr_q      <= req_write;
        active    <= 1'b1;
        cs_q      <= req_cs;
        bus_addr  <= req_addr;
        bus_dq_o  <= req_wdata;
        bus_dq_oe <= req_write;
        hold_cnt  <= (t_whold == '0) ? ONE : t_whold;
      end
      if (release_now && !wr_q) rd_data <= bus_dq_i;
      if (phase == PH_RECOV) begin
        if (hold_cnt == ONE || recov_last) bus_dq_oe <= 1'b0;
        if (hold_cnt != ONE) hold_cnt <= hold_cnt - ONE;
      end
      if (recov_last) active <= 1'b0;
    end
  end

  assign bus_cs_n = active ? ~cs_q : '1;
  assign bus_rd_n = !((phase == PH_STROBE) && !wr_q);
  assign bus_wr_n = !((phase == PH_STROBE) && wr_q);

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n)); // R11
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_dq_oe); // R6
  AST_ADDR_STABLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STROBE) |=> $stable(bus_addr) && $stable(bus_cs_n)); // R2
  AST_WRITE_DATA_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> bus_dq_oe); // R5
endmodule

// File: rtl/pio_access_seq.sv
module pio_access_seq
  import pio_seq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 3,
  parameter int CS_W        = 2,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CS_W-1:0]   req_cs,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CNT_W-1:0]  cfg_t_setup,
  input  logic [CNT_W-1:0]  cfg_t_strobe,
  input  logic [CNT_W-1:0]  cfg_t_recov,
  input  logic [CNT_W-1:0]  cfg_t_whold,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [CS_W-1:0]   bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [DATA_W-1:0] bus_dq_o,
  output logic              bus_dq_oe,
  input  logic [DATA_W-1:0] bus_dq_i,
  input  logic              bus_rdy
);
  pio_phase_e phase;
  logic       rdy_s;
  logic       start;
  logic       release_now;
  logic       recov_last;

  assign req_ready = (phase == PH_IDLE);
  assign start     = req_valid && req_ready;

  pio_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (bus_rdy),
    .sync_out (rdy_s)
  );

  pio_phase_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .t_setup     (cfg_t_setup),
    .t_strobe    (cfg_t_strobe),
    .t_recov     (cfg_t_recov),
    .rdy_s       (rdy_s),
    .phase       (phase),
    .release_now (release_now),
    .recov_last  (recov_last),
    .done        (done)
  );

  pio_bus_drv #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CS_W(CS_W), .CNT_W(CNT_W)
  ) u_drv (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_cs      (req_cs),
    .req_wdata   (req_wdata),
    .t_whold     (cfg_t_whold),
    .phase       (phase),
    .release_now (release_now),
    .recov_last  (recov_last),
    .bus_dq_i    (bus_dq_i),
    .bus_addr    (bus_addr),
    .bus_cs_n    (bus_cs_n),
    .bus_rd_n    (bus_rd_n),
    .bus_wr_n    (bus_wr_n),
    .bus_dq_o    (bus_dq_o),
    .bus_dq_oe   (bus_dq_oe),
    .rd_data     (rd_data)
  );

  AST_DONE_MEANS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready); // R10
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !req_ready); // R10
endmodule

// File: tb/pio_access_seq_tb_top.sv
`timescale 1ns/1ps
module pio_access_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [1:0]  req_cs = '0;
  logic [15:0] req_wdata = '0;
  logic [7:0]  cfg_t_setup = 8'd1, cfg_t_strobe = 8'd1, cfg_t_recov = 8'd1, cfg_t_whold = 8'd1;
  logic        done;
  logic [15:0] rd_data;
  logic [2:0]  bus_addr;
  logic [1:0]  bus_cs_n;
  logic        bus_rd_n, bus_wr_n;
  logic [15:0] bus_dq_o;
  logic        bus_dq_oe;
  logic [15:0] bus_dq_i = '0;
  logic        bus_rdy = 1'b1;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  pio_access_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_cs(req_cs), .req_wdata(req_wdata),
    .cfg_t_setup(cfg_t_setup), .cfg_t_strobe(cfg_t_strobe), .cfg_t_recov(cfg_t_recov),
    .cfg_t_whold(cfg_t_whold), .done(done), .rd_data(rd_data), .bus_addr(bus_addr),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_dq_o(bus_dq_o),
    .bus_dq_oe(bus_dq_oe), .bus_dq_i(bus_dq_i), .bus_rdy(bus_rdy)
  );

  function automatic int lmin1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int exp_strobe(input int t2, input int k);
    int w = lmin1(t2);
    if (k > 0 && k + 2 > w) w = k + 2;
    return w;
  endfunction

  function automatic int exp_hold(input bit wr, input int t4, input int te);
    if (!wr) return 0;
    return (lmin1(t4) < lmin1(te)) ? lmin1(t4) : lmin1(te);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // entry and exit at a falling edge; keep=1 leaves next request valid
  task automatic do_access(input bit wr, input logic [2:0] a, input logic [1:0] cs,
                           input logic [15:0] wd, input int t1, input int t2,
                           input int te, input int t4, input int k, input bit keep,
                           input logic [1:0] next_cs);
    int su = 0, st = 0, rc = 0, oec = 0, guard = 0;
    bit seen = 0, addr_ok = 1, drive_ok = 1, kind_ok = 1, busy_ok = 1;
    logic [15:0] last_d = '0;
    if (k > 0) begin
      bus_rdy = 1'b0;
      repeat (3) @(negedge clk);
    end
    req_write = wr; req_addr = a; req_cs = cs; req_wdata = wd;
    cfg_t_setup = 8'(t1); cfg_t_strobe = 8'(t2); cfg_t_recov = 8'(te); cfg_t_whold = 8'(t4);
    req_valid = 1'b1;
    @(negedge clk);
    // R8: scramble counts once the request has been taken
    cfg_t_setup = 8'($urandom_range(0, 6)); cfg_t_strobe = 8'($urandom_range(0, 6));
    cfg_t_recov = 8'($urandom_range(0, 6)); cfg_t_whold = 8'($urandom_range(0, 6));
    if (keep) begin
      req_write = 1'b0; req_addr = ~a; req_cs = next_cs;
    end else begin
      req_valid = 1'b0;
    end
    while (!done && guard < 1000) begin
      guard++;
      if (req_ready) busy_ok = 0;
      if (!bus_rd_n || !bus_wr_n) begin
        seen = 1; st++;
        if (wr ? (bus_rd_n !== 1'b1) : (bus_wr_n !== 1'b1)) kind_ok = 0;
        if (wr && (!bus_dq_oe || bus_dq_o !== wd)) drive_ok = 0;
        if (!wr && bus_dq_oe) drive_ok = 0;
        if (bus_addr !== a || bus_cs_n !== ~cs) addr_ok = 0;
        if (!wr) begin
          last_d = 16'($urandom);
          bus_dq_i = last_d;
        end
        if (st == k) bus_rdy = 1'b1;
      end else if (!seen) begin
        su++;
        if (bus_addr !== a || bus_cs_n !== ~cs) addr_ok = 0;
        if (bus_dq_oe !== wr) drive_ok = 0;
        if (wr && bus_dq_o !== wd) drive_ok = 0;
      end else begin
        rc++;
        if (bus_dq_oe) oec++;
        if (bus_addr !== a || bus_cs_n !== ~cs) addr_ok = 0;
      end
      @(negedge clk);
    end
    check(guard < 1000, "R4 access completes", guard, 0);
    check(su == lmin1(t1), "R2/R8/R9 setup cycles", su, lmin1(t1));
    check(st == exp_strobe(t2, k), k > 0 ? "R7 stretched strobe" : "R3/R9 strobe cycles",
          st, exp_strobe(t2, k));
    check(rc == lmin1(te), "R4 recovery cycles", rc, lmin1(te));
    check(oec == exp_hold(wr, t4, te), "R5 write hold cycles", oec, exp_hold(wr, t4, te));
    check(addr_ok, "R2/R4 address and selects held", addr_ok, 1);
    check(drive_ok, wr ? "R5 write drive" : "R6 no drive on read", drive_ok, 1);
    check(kind_ok, "R11 strobe kind", kind_ok, 1);
    check(busy_ok && req_ready, "R10 busy then ready at done", busy_ok, 1);
    check(bus_cs_n == 2'b11, "R4 selects released at done", bus_cs_n, 3);
    if (!wr) check(rd_data == last_d, "R6 read capture", rd_data, last_d);
    bus_rdy = 1'b1;
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d3a_5e77));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(bus_rd_n && bus_wr_n && bus_cs_n == 2'b11 && !bus_dq_oe && req_ready && !done,
          "R1 idle after reset", {bus_rd_n, bus_wr_n, bus_cs_n, bus_dq_oe, req_ready, done}, 7'b1111010);
    repeat (3) @(negedge clk);

    do_access(1, 3'd5, 2'b01, 16'hA55A, 2, 3, 2, 4, 0, 0, 2'b00);
    do_access(0, 3'd2, 2'b10, 16'h0000, 1, 1, 1, 1, 0, 0, 2'b00);
    do_access(1, 3'd7, 2'b11, 16'h1234, 0, 0, 0, 0, 0, 0, 2'b00);   // R9 all zero
    do_access(1, 3'd1, 2'b01, 16'hFFFF, 1, 2, 4, 2, 0, 0, 2'b00);   // R5 hold < recov
    do_access(0, 3'd4, 2'b01, 16'h0000, 1, 2, 3, 1, 5, 0, 2'b00);   // R7 ready extends
    do_access(0, 3'd6, 2'b10, 16'h0000, 2, 4, 1, 1, 1, 0, 2'b00);   // R7 width dominates
    do_access(1, 3'd3, 2'b10, 16'h5A5A, 1, 1, 2, 0, 4, 0, 2'b00);   // R7 on write

    // R10 done and next acceptance in one cycle
    do_access(1, 3'd2, 2'b01, 16'hC0DE, 1, 2, 1, 1, 0, 1, 2'b10);
    @(negedge clk);
    check(bus_cs_n == 2'b01 && !req_ready && !done, "R10 queued request taken at done",
          {bus_cs_n, req_ready, done}, 4'b0100);
    req_valid = 1'b0;
    begin
      int g = 0;
      while (!done && g < 200) begin g++; @(negedge clk); end
      check(done, "R10 queued access completes", done, 1);
    end
    @(negedge clk);

    for (int i = 0; i < 40; i++) begin
      bit wr = 1'($urandom);
      int k = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 6)) : 0;
      do_access(wr, 3'($urandom), 2'($urandom), 16'($urandom),
                $urandom_range(0, 5), $urandom_range(0, 5), $urandom_range(0, 5),
                $urandom_range(0, 5), k, 0, 2'b00);
      if ($urandom_range(0, 1) == 1) @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule